// File: doc/BRIEF.md
# Prioritized Input Failover Selector

This block decides which of three candidate sources feeds the video path: the optical input, the electrical input, or an internal source (test generator or mute). In automatic mode it walks a three-slot priority list. It moves down the list when the active source stays bad for a hold interval, and it moves back up when a higher slot stays usable for a lock interval. A two-bit rule input chooses which status bit counts as "bad": loss of signal, loss of lock, or errors detected in the frame.

Loss of signal can be seen on every physical input at the same time. Under that rule a single hold interval can skip any failed slot and land on the first usable one. The lock and error status is only known for the input that is currently selected. Under those two rules the selector therefore steps down exactly one slot per hold interval.

In manual mode the source is forced. The block still reports a freeze while that source is bad, but it never switches away from it. Both timers advance only on a one-cycle `tick` strobe, for example a one-second pulse, so the default of three ticks gives a three-second hold and a three-second lock.

Top module: `input_failover_sel`

## Requirements
- R1: Source codes are 0 = optical, 1 = electrical, 2 = generator, 3 = mute. Priority slot k is `prio_list[2k+1:2k]`, with slot 0 the highest. After reset, in automatic mode, `sel_src` is the source in slot 0.
- R2: The rule code selects which bit marks a physical source bad: 0 = loss of lock, 1 (or 3) = loss of signal, 2 = error detected. Generator and mute are never bad.
- R3: A switch away from a bad source happens only on the HOLD_TICKS-th `tick` seen while that source is continuously bad. Any good cycle restarts the count, and without ticks no switch happens.
- R4: `valid` is high exactly when the selected source is good. `freeze` is high from the first bad cycle until the source recovers, a switch-over occurs, or the source is declared lost.
- R5: Under the loss-of-signal rule, hold expiry moves to the first lower slot whose source has no loss of signal. A generator or mute slot counts as usable. This can skip slot 1 in one hold interval.
- R6: Under the lock and error rules, hold expiry moves to the next lower slot without checking it, so each step down costs one full hold interval.
- R7: Any slot that names the currently selected source is skipped when the selector searches for a new slot.
- R8: In automatic mode, the highest slot above the current one whose source differs from the current one and shows no loss of signal becomes the selection after it stays the candidate for LOCK_TICKS ticks. If the candidate disappears or changes, the lock count restarts.
- R9: When the lock interval and the hold interval expire on the same tick, the return to the higher slot wins.
- R10: When the hold interval expires and there is no lower slot to move to, the selection stays put, `freeze` drops and `valid` stays low until the source recovers.
- R11: In manual mode `sel_src` equals `manual_src`. The hold interval only ends the freeze and never causes a switch.
- R12: When the block goes from manual mode back to automatic mode, the search restarts at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer strobe, one cycle per time unit |
| auto_mode | input | 1 | 1 = walk the priority list, 0 = use `manual_src` |
| manual_src | input | 2 | Forced source code in manual mode |
| loss_rule | input | 2 | Bad-status rule selector |
| prio_list | input | 6 | Three two-bit source codes, slot 0 in the low bits |
| opt_los | input | 1 | Optical loss of signal |
| opt_lol | input | 1 | Optical loss of lock |
| opt_err | input | 1 | Optical frame error detected |
| ele_los | input | 1 | Electrical loss of signal |
| ele_lol | input | 1 | Electrical loss of lock |
| ele_err | input | 1 | Electrical frame error detected |
| sel_src | output | 2 | Selected source code |
| freeze | output | 1 | Hold the last good picture |
| valid | output | 1 | Selected source is currently good |

## Verification
The step-down caused by hold expiry and the step-up caused by lock expiry can fall on the same tick. The bench provokes this by parking the selection on slot 1 and making slot 1 bad while slot 0 is still absent, so the hold count starts first. It then restores slot 0 one tick later, so that with a hold of three ticks and a lock of two ticks both counts end on the same strobe. The outcome is judged correct only if the selection returns to slot 0; landing on the generator in slot 2 is a failure.

// File: rtl/input_failover_sel.sv
module input_failover_sel #(
  parameter int HOLD_TICKS = 3,
  parameter int LOCK_TICKS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       auto_mode,
  input  logic [1:0] manual_src,
  input  logic [1:0] loss_rule,
  input  logic [5:0] prio_list,
  input  logic       opt_los,
  input  logic       opt_lol,
  input  logic       opt_err,
  input  logic       ele_los,
  input  logic       ele_lol,
  input  logic       ele_err,
  output logic [1:0] sel_src,
  output logic       freeze,
  output logic       valid
);

  localparam int HW = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;
  localparam int LW = (LOCK_TICKS > 1) ? $clog2(LOCK_TICKS) : 1;
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_TICKS - 1);
  localparam logic [LW-1:0] LOCK_LAST = LW'(LOCK_TICKS - 1);
  localparam logic [1:0] RULE_LOL = 2'd0;
  localparam logic [1:0] RULE_ERR = 2'd2;
  localparam int NSLOT = 3;

  logic [1:0]    slot_src [NSLOT];
  logic [NSLOT-1:0] present;
  logic [1:0]    cur_slot, last_src, auto_src;
  logic [HW-1:0] hold_cnt;
  logic [LW-1:0] lock_cnt;
  logic [1:0]    lock_slot;
  logic          lost;
  logic [2:0]    opt_st, ele_st;
  logic [1:0]    ridx;
  logic          rule_los, bad, chg;
  logic          down_ok, up_ok;
  logic [1:0]    down_slot, up_slot;
  logic          hold_fire, lock_fire;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign slot_src[g] = prio_list[2*g +: 2];
    assign present[g]  = slot_src[g][1] | (slot_src[g][0] ? !ele_los : !opt_los);
  end

  always_comb begin
    case (cur_slot)
      2'd1:    auto_src = slot_src[1];
      2'd2:    auto_src = slot_src[2];
      default: auto_src = slot_src[0];
    endcase
  end

  assign sel_src  = auto_mode ? auto_src : manual_src;
  assign opt_st   = {opt_err, opt_lol, opt_los};
  assign ele_st   = {ele_err, ele_lol, ele_los};
  assign ridx     = (loss_rule == RULE_LOL) ? 2'd1 : (loss_rule == RULE_ERR) ? 2'd2 : 2'd0;
  assign rule_los = (loss_rule != RULE_LOL) && (loss_rule != RULE_ERR);
  assign bad      = !sel_src[1] && (sel_src[0] ? ele_st[ridx] : opt_st[ridx]);
  assign chg      = sel_src != last_src;

  always_comb begin
    down_ok   = 1'b0;
    down_slot = cur_slot;
    up_ok     = 1'b0;
    up_slot   = 2'd0;
    for (int j = NSLOT - 1; j >= 0; j--) begin
      if (j > int'(cur_slot) && slot_src[j] != sel_src && (!rule_los || present[j])) begin
        down_ok   = 1'b1;
        down_slot = 2'(j);
      end
      if (j < int'(cur_slot) && slot_src[j] != sel_src && present[j]) begin
        up_ok   = 1'b1;
        up_slot = 2'(j);
      end
    end
  end

  assign hold_fire = tick && bad && !lost && !chg && (hold_cnt == HOLD_LAST);
  assign lock_fire = auto_mode && tick && up_ok && (up_slot == lock_slot) && !chg &&
                     (lock_cnt == LOCK_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_slot  <= 2'd0;
      last_src  <= 2'd0;
      hold_cnt  <= '0;
      lock_cnt  <= '0;
      lock_slot <= 2'd0;
      lost      <= 1'b0;
    end else begin
      last_src <= sel_src;

      if (chg || !bad || lost) hold_cnt <= '0;
      else if (tick) hold_cnt <= (hold_cnt == HOLD_LAST) ? '0 : hold_cnt + 1'b1;

      if (!auto_mode || !up_ok || up_slot != lock_slot || chg) begin
        lock_cnt  <= '0;
        lock_slot <= up_slot;
      end else if (tick) begin
        lock_cnt <= (lock_cnt == LOCK_LAST) ? '0 : lock_cnt + 1'b1;
      end

      if (!auto_mode)             cur_slot <= 2'd0;
      else if (lock_fire)         cur_slot <= lock_slot;
      else if (hold_fire && down_ok) cur_slot <= down_slot;

      if (chg || !bad) lost <= 1'b0;
      else if (hold_fire && !lock_fire && !(auto_mode && down_ok)) lost <= 1'b1;
    end
  end

  assign valid  = !bad;
  assign freeze = bad && !lost;

endmodule

module input_failover_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       auto_mode,
  input logic [1:0] manual_src,
  input logic [1:0] loss_rule,
  input logic [5:0] prio_list,
  input logic       opt_los,
  input logic       ele_los,
  input logic [1:0] sel_src,
  input logic       freeze,
  input logic       valid,
  input logic       lost
);

  assert_switch_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_mode && $past(auto_mode) && $stable(prio_list) && !$past(tick)) |-> $stable(sel_src));

  assert_freeze_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(freeze) |-> (valid || lost || !$stable(sel_src)));

  assert_los_target_present_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_mode && $past(auto_mode) && loss_rule == 2'd1 && $stable(loss_rule) &&
     $stable(prio_list) && !$stable(sel_src))
    |-> (sel_src[1] || (sel_src[0] ? !$past(ele_los) : !$past(opt_los))));

  assert_lost_keeps_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(lost) && $stable(auto_mode) && $stable(prio_list) && $stable(manual_src))
    |-> $stable(sel_src));

  assert_manual_no_switch_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_mode && $past(!auto_mode) && $stable(manual_src)) |-> $stable(sel_src));

endmodule

bind input_failover_sel input_failover_sel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .auto_mode(auto_mode),
  .manual_src(manual_src), .loss_rule(loss_rule), .prio_list(prio_list),
  .opt_los(opt_los), .ele_los(ele_los), .sel_src(sel_src),
  .freeze(freeze), .valid(valid), .lost(lost)
);

// File: tb/input_failover_sel_bench.sv
module input_failover_sel_bench;

  localparam logic [5:0] P   = {2'd2, 2'd1, 2'd0};
  localparam int         NV  = 17;
  // {auto, msrc, rule, prio, st{ee,el,es,oe,ol,os}, nticks, esrc, efrz, eval}
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 2'd0, 2'd1, P, 6'b000000, 4'd0, 2'd0, 1'b0, 1'b1},  // R1
    {1'b1, 2'd0, 2'd1, P, 6'b001001, 4'd2, 2'd0, 1'b1, 1'b0},  // R4
    {1'b1, 2'd0, 2'd1, P, 6'b001001, 4'd1, 2'd2, 1'b0, 1'b1},  // R5 jump
    {1'b1, 2'd0, 2'd1, P, 6'b001000, 4'd1, 2'd2, 1'b0, 1'b1},  // R8
    {1'b1, 2'd0, 2'd1, P, 6'b001000, 4'd1, 2'd0, 1'b0, 1'b1},  // R8
    {1'b1, 2'd0, 2'd0, P, 6'b000011, 4'd3, 2'd1, 1'b0, 1'b1},  // R6
    {1'b1, 2'd0, 2'd0, P, 6'b010011, 4'd2, 2'd1, 1'b1, 1'b0},  // R2
    {1'b1, 2'd0, 2'd0, P, 6'b010011, 4'd1, 2'd2, 1'b0, 1'b1},  // R6
    {1'b1, 2'd0, 2'd2, P, 6'b000000, 4'd2, 2'd0, 1'b0, 1'b1},  // R8
    {1'b1, 2'd0, 2'd2, P, 6'b000100, 4'd2, 2'd0, 1'b1, 1'b0},  // R2
    {1'b1, 2'd0, 2'd2, P, 6'b000100, 4'd1, 2'd1, 1'b0, 1'b1},  // R6
    {1'b0, 2'd0, 2'd2, P, 6'b000100, 4'd0, 2'd0, 1'b1, 1'b0},  // R11
    {1'b0, 2'd0, 2'd2, P, 6'b000100, 4'd3, 2'd0, 1'b0, 1'b0},  // R11
    {1'b0, 2'd0, 2'd2, P, 6'b000100, 4'd5, 2'd0, 1'b0, 1'b0},  // R10
    {1'b0, 2'd0, 2'd2, P, 6'b000000, 4'd0, 2'd0, 1'b0, 1'b1},  // R4
    {1'b0, 2'd2, 2'd1, P, 6'b111111, 4'd4, 2'd2, 1'b0, 1'b1},  // R2
    {1'b1, 2'd0, 2'd1, P, 6'b000000, 4'd0, 2'd0, 1'b0, 1'b1}   // R12
  };

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, auto_mode = 1'b1;
  logic [1:0] manual_src = 2'd0, loss_rule = 2'd1;
  logic [5:0] prio_list = P;
  logic [5:0] st = 6'b0;
  logic [1:0] sel_src;
  logic freeze, valid;
  int vectors = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  input_failover_sel #(.HOLD_TICKS(3), .LOCK_TICKS(2)) u_input_failover_sel (
    .clk(clk), .rst_n(rst_n), .tick(tick), .auto_mode(auto_mode),
    .manual_src(manual_src), .loss_rule(loss_rule), .prio_list(prio_list),
    .opt_los(st[0]), .opt_lol(st[1]), .opt_err(st[2]),
    .ele_los(st[3]), .ele_lol(st[4]), .ele_err(st[5]),
    .sel_src(sel_src), .freeze(freeze), .valid(valid)
  );

  function automatic string row_req(int i);
    case (i)
      0: return "R1";  1: return "R4";  2: return "R5";  3: return "R8";
      4: return "R8";  5: return "R6";  6: return "R2";  7: return "R6";
      8: return "R8";  9: return "R2";  10: return "R6"; 11: return "R11";
      12: return "R11"; 13: return "R10"; 14: return "R4"; 15: return "R2";
      default: return "R12";
    endcase
  endfunction

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      idle(2);
    end
  endtask

  task automatic check(string req, logic [1:0] es, logic ef, logic ev);
    vectors++;
    if (sel_src !== es || freeze !== ef || valid !== ev) begin
      errors++;
      $display("FAIL %s: got src=%0d freeze=%0b valid=%0b, expected src=%0d freeze=%0b valid=%0b",
               req, sel_src, freeze, valid, es, ef, ev);
    end
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    check("R1", 2'd0, 1'b0, 1'b1);  // reset state: slot 0 optical

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      auto_mode  = VEC[i][24];
      manual_src = VEC[i][23:22];
      loss_rule  = VEC[i][21:20];
      prio_list  = VEC[i][19:14];
      st         = VEC[i][13:8];
      idle(2);
      pulse(int'(VEC[i][7:4]));
      idle(2);
      check(row_req(i), VEC[i][3:2], VEC[i][1], VEC[i][0]);
    end

    // R3: no ticks, no switch
    st = 6'b000001;
    idle(50);
    check("R3", 2'd0, 1'b1, 1'b0);
    // R3: hold restarts on a good cycle
    pulse(2);
    st = 6'b000000; idle(3);
    st = 6'b000001; idle(2);
    pulse(2);
    check("R3", 2'd0, 1'b1, 1'b0);
    pulse(1);
    check("R3", 2'd1, 1'b0, 1'b1);
    // R8: lock restarts when the candidate vanishes
    st = 6'b000000; idle(2);
    pulse(1);
    st = 6'b000001; idle(3);
    st = 6'b000000; idle(2);
    pulse(1);
    check("R8", 2'd1, 1'b0, 1'b1);
    pulse(1);
    check("R8", 2'd0, 1'b0, 1'b1);
    // R9: hold and lock expire on the same tick
    st = 6'b000001; idle(2);
    pulse(3);
    check("R9", 2'd1, 1'b0, 1'b1);
    st = 6'b001001; idle(2);
    pulse(1);
    st = 6'b001000; idle(2);
    pulse(1);
    check("R9", 2'd1, 1'b1, 1'b0);
    pulse(1);
    check("R9", 2'd0, 1'b0, 1'b1);
    // R7: duplicate slot skipped under loss-of-lock rule
    st = 6'b000000; loss_rule = 2'd0;
    prio_list = {2'd1, 2'd0, 2'd0}; idle(2);
    st = 6'b000010; idle(2);
    pulse(3);
    check("R7", 2'd1, 1'b0, 1'b1);
    // R10: no target left, selection kept and declared lost
    auto_mode = 1'b0; idle(2);
    auto_mode = 1'b1; loss_rule = 2'd1;
    prio_list = {2'd0, 2'd0, 2'd0}; st = 6'b000000; idle(2);
    st = 6'b000001; idle(2);
    pulse(3);
    check("R10", 2'd0, 1'b0, 1'b0);
    st = 6'b000000; idle(2);
    check("R10", 2'd0, 1'b0, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      vectors++;
      errors++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule